// File: doc/BRIEF.md
# ATM Cell Output Formatter

This block sits between a receive cell buffer and the receive-cell output bus. It pulls the 52 content bytes of each ATM cell (4 header bytes, then 48 payload bytes) one at a time from the buffer. It emits them as a stream of output transfers, adding user-defined bytes (UDBs) at fixed positions. In the narrow mode, each transfer carries one byte on the low lane. In the wide mode, each transfer carries a pair of bytes, with the earlier byte on the upper lane. The wide mode has two layouts, and they differ in where the second UDB goes.

The first UDB carries a programmable value from a register input. The second UDB, which exists only in the wide layouts, is always zero. The width and layout selections are sampled when a cell starts, so a cell is never split across two formats. Downstream back-pressure through a ready input freezes both the output word and the byte sequencer.

Top module: `atm_cell_out_fmt`

## Requirements
- R1: While reset is asserted, and after its release while no source byte is offered, out_valid, out_soc and src_take are all low.
- R2: With wide_mode low, each cell is 53 transfers. Transfers 0 to 3 carry header bytes 1 to 4, transfer 4 carries udb1_val, and transfers 5 to 52 carry payload bytes 1 to 48. The byte is on out_data[7:0] and out_data[15:8] is zero.
- R3: With wide_mode high and alt_layout low, each cell is 27 words: {H1,H2}, {H3,H4}, {udb1_val,8'h00}, then {P1,P2} through {P47,P48}.
- R4: With wide_mode high and alt_layout high, each cell is 27 words: {H1,H2}, {H3,H4}, {udb1_val,P1}, {P2,P3} through {P46,P47}, then {P48,8'h00}.
- R5: In the wide mode, the earlier byte of each pair is on out_data[15:8] and the later byte is on out_data[7:0].
- R6: out_soc is high on the first transfer of every cell and low on all other transfers.
- R7: A change of wide_mode or alt_layout made in the middle of a cell does not alter that cell. It applies from the next cell onward.
- R8: While out_valid is high and out_ready is low, out_data, out_soc and out_valid hold their values and no source byte is taken.
- R9: src_take is asserted only while src_valid is high. Each cell consumes exactly 52 source bytes, each taken once and in order, and gaps in src_valid do not change the output content.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wide_mode | input | 1 | 1: two bytes per transfer; 0: one byte per transfer |
| alt_layout | input | 1 | Wide layout select: 0 puts the zero UDB after UDB1, 1 puts it after the last payload byte |
| udb1_val | input | 8 | Value driven in the first user-defined byte |
| src_valid | input | 1 | Cell buffer offers a byte |
| src_byte | input | 8 | Offered cell byte (header then payload) |
| src_take | output | 1 | Offered byte is consumed at this clock edge |
| out_data | output | 16 | Output word; narrow mode uses bits 7:0 |
| out_soc | output | 1 | Transfer is the first of a cell |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Downstream accepts the word this cycle |

## Verification
The assertions assume that the cell buffer keeps src_valid and src_byte steady until it sees src_take. They also assume that every cell comes in as a run of exactly 52 bytes, with no framing signal on the source side. The stimulus offers bytes from one continuous counter-indexed sequence, so byte boundaries and cell boundaries follow from the take count alone. It changes the width and layout selections only while the block is idle at a cell start, apart from the deliberate mid-cell changes. udb1_val changes only between cells, because the block reads it live at the UDB position.

// File: rtl/fmt_pkg.sv
package fmt_pkg;
   // Source of the byte placed in one slot of the output sequence
   typedef enum logic [1:0] {
      SLOT_SRC  = 2'd0,   // header or payload byte from the cell buffer
      SLOT_UDB  = 2'd1,   // first user-defined byte (programmable)
      SLOT_ZERO = 2'd2    // second user-defined byte, constant zero
   } slot_kind_e;
endpackage

// File: rtl/fmt_slot_decode.sv
module fmt_slot_decode
   import fmt_pkg::*;
#(
   parameter int HDR_BYTES = 4,
   parameter int PAY_BYTES = 48,
   parameter int SLOT_W    = 6
) (
   input  logic [SLOT_W-1:0] slot,
   input  logic              wide,
   input  logic              alt,
   output slot_kind_e        kind,
   output logic              last
);
   localparam logic [SLOT_W-1:0] UDB_IDX     = SLOT_W'(HDR_BYTES);
   localparam logic [SLOT_W-1:0] GAP_IDX     = SLOT_W'(HDR_BYTES + 1);
   localparam logic [SLOT_W-1:0] TAIL_IDX    = SLOT_W'(HDR_BYTES + PAY_BYTES + 1);
   localparam logic [SLOT_W-1:0] NARROW_LAST = SLOT_W'(HDR_BYTES + PAY_BYTES);
   localparam logic [SLOT_W-1:0] WIDE_LAST   = SLOT_W'(HDR_BYTES + PAY_BYTES + 1);

   always_comb begin
      kind = SLOT_SRC;
      if (slot == UDB_IDX) begin
         kind = SLOT_UDB;
      end else if (wide && !alt && (slot == GAP_IDX)) begin
         kind = SLOT_ZERO;
      end else if (wide && alt && (slot == TAIL_IDX)) begin
         kind = SLOT_ZERO;
      end
   end

   assign last = (slot == (wide ? WIDE_LAST : NARROW_LAST));
endmodule

// File: rtl/fmt_config_latch.sv
module fmt_config_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic at_start,
   input  logic wide_in,
   input  logic alt_in,
   output logic wide_eff,
   output logic alt_eff
);
   logic wide_q;
   logic alt_q;

   // Track live inputs while parked at a cell start; freeze once the cell runs
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wide_q <= 1'b0;
         alt_q  <= 1'b0;
      end else if (at_start) begin
         wide_q <= wide_in;
         alt_q  <= alt_in;
      end
   end

   assign wide_eff = at_start ? wide_in : wide_q;
   assign alt_eff  = at_start ? alt_in  : alt_q;
endmodule

// File: rtl/fmt_word_packer.sv
module fmt_word_packer #(
   parameter int BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide,
   input  logic [BYTE_W-1:0]   byte_in,
   input  logic                load_hi,
   input  logic                load_word,
   input  logic                soc_in,
   input  logic                out_ready,
   output logic [2*BYTE_W-1:0] out_data,
   output logic                out_valid,
   output logic                out_soc,
   output logic                out_free
);
   localparam int LANES = 2;

   logic [BYTE_W-1:0]   hi_q;
   logic [2*BYTE_W-1:0] word_next;

   // Lane 0 always takes the current byte; upper lanes take the held byte in wide mode
   for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
      if (ln == 0) begin : g_low
         assign word_next[BYTE_W-1:0] = byte_in;
      end else begin : g_high
         assign word_next[ln*BYTE_W +: BYTE_W] = wide ? hi_q : '0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q      <= '0;
         out_data  <= '0;
         out_valid <= 1'b0;
         out_soc   <= 1'b0;
      end else begin
         if (load_hi) begin
            hi_q <= byte_in;
         end
         if (load_word) begin
            out_data  <= word_next;
            out_valid <= 1'b1;
            out_soc   <= soc_in;
         end else if (out_ready) begin
            out_valid <= 1'b0;
         end
      end
   end

   assign out_free = !out_valid || out_ready;
endmodule

// File: rtl/atm_cell_out_fmt.sv
module atm_cell_out_fmt
   import fmt_pkg::*;
#(
   parameter int BYTE_W    = 8,
   parameter int HDR_BYTES = 4,
   parameter int PAY_BYTES = 48
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wide_mode,
   input  logic                alt_layout,
   input  logic [BYTE_W-1:0]   udb1_val,
   input  logic                src_valid,
   input  logic [BYTE_W-1:0]   src_byte,
   output logic                src_take,
   output logic [2*BYTE_W-1:0] out_data,
   output logic                out_soc,
   output logic                out_valid,
   input  logic                out_ready
);
   localparam int SLOTS  = HDR_BYTES + PAY_BYTES + 2;
   localparam int SLOT_W = $clog2(SLOTS);

   // Elaboration-time parameter checks
   if (BYTE_W < 1) begin : g_bad_byte_w
      $error("BYTE_W must be at least 1");
   end
   if (HDR_BYTES < 2) begin : g_bad_hdr
      $error("HDR_BYTES must be at least 2");
   end
   if (PAY_BYTES < 2) begin : g_bad_pay
      $error("PAY_BYTES must be at least 2");
   end
   if (((HDR_BYTES + PAY_BYTES) % 2) != 0) begin : g_bad_parity
      $error("HDR_BYTES + PAY_BYTES must be even for whole wide words");
   end

   logic [SLOT_W-1:0] slot_q;
   logic              at_start;
   logic              wide_eff;
   logic              alt_eff;
   slot_kind_e        kind;
   logic              slot_last;
   logic [BYTE_W-1:0] cur_byte;
   logic              byte_ok;
   logic              completes;
   logic              out_free;
   logic              adv;
   logic              first_word;

   assign at_start = (slot_q == '0);

   fmt_config_latch u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .at_start (at_start),
      .wide_in  (wide_mode),
      .alt_in   (alt_layout),
      .wide_eff (wide_eff),
      .alt_eff  (alt_eff)
   );

   fmt_slot_decode #(
      .HDR_BYTES (HDR_BYTES),
      .PAY_BYTES (PAY_BYTES),
      .SLOT_W    (SLOT_W)
   ) u_dec (
      .slot (slot_q),
      .wide (wide_eff),
      .alt  (alt_eff),
      .kind (kind),
      .last (slot_last)
   );

   always_comb begin
      unique case (kind)
         SLOT_UDB:  cur_byte = udb1_val;
         SLOT_ZERO: cur_byte = '0;
         default:   cur_byte = src_byte;
      endcase
   end

   // A slot advances when its byte exists and the output side is not stalled
   assign byte_ok    = (kind != SLOT_SRC) || src_valid;
   assign completes  = !wide_eff || slot_q[0];
   assign adv        = byte_ok && out_free;
   assign src_take   = adv && (kind == SLOT_SRC);
   assign first_word = wide_eff ? (slot_q == SLOT_W'(1)) : at_start;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
      end else if (adv) begin
         slot_q <= slot_last ? '0 : slot_q + 1'b1;
      end
   end

   fmt_word_packer #(
      .BYTE_W (BYTE_W)
   ) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .wide      (wide_eff),
      .byte_in   (cur_byte),
      .load_hi   (adv && !completes),
      .load_word (adv && completes),
      .soc_in    (first_word),
      .out_ready (out_ready),
      .out_data  (out_data),
      .out_valid (out_valid),
      .out_soc   (out_soc),
      .out_free  (out_free)
   );
endmodule

// File: rtl/atm_cell_out_fmt_chk.sv
module atm_cell_out_fmt_chk #(
   parameter int BYTE_W    = 8,
   parameter int HDR_BYTES = 4,
   parameter int PAY_BYTES = 48
) (
   input logic                clk,
   input logic                rst_n,
   input logic                src_valid,
   input logic                src_take,
   input logic [2*BYTE_W-1:0] out_data,
   input logic                out_soc,
   input logic                out_valid,
   input logic                out_ready
);
   localparam int NARROW_XFERS = HDR_BYTES + PAY_BYTES + 1;
   localparam int WIDE_XFERS   = (HDR_BYTES + PAY_BYTES + 2) / 2;
   localparam int CNT_W        = $clog2(NARROW_XFERS + 2) + 1;

   logic             hs;
   logic [CNT_W-1:0] xfer_cnt;
   logic             started;

   assign hs = out_valid && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_cnt <= '0;
         started  <= 1'b0;
      end else if (hs) begin
         if (out_soc) begin
            xfer_cnt <= CNT_W'(1);
            started  <= 1'b1;
         end else begin
            xfer_cnt <= xfer_cnt + 1'b1;
         end
      end
   end

   // R8: a stalled word is held unchanged
   a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_soc)));

   // R8: no byte is consumed while the output is stalled
   a_r8_no_take_in_stall: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !src_take);

   // R9: bytes are only consumed when offered
   a_r9_take_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
      src_take |-> src_valid);

   // R6: the previous cell had one of the two legal transfer counts
   a_r6_cell_length: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && out_soc && started) |->
         ((xfer_cnt == CNT_W'(NARROW_XFERS)) || (xfer_cnt == CNT_W'(WIDE_XFERS))));

   // R6: no cell runs longer than the narrow count without a new start
   a_r6_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      (hs && !out_soc && started) |-> (xfer_cnt < CNT_W'(NARROW_XFERS)));
endmodule

bind atm_cell_out_fmt atm_cell_out_fmt_chk #(
   .BYTE_W    (BYTE_W),
   .HDR_BYTES (HDR_BYTES),
   .PAY_BYTES (PAY_BYTES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_take  (src_take),
   .out_data  (out_data),
   .out_soc   (out_soc),
   .out_valid (out_valid),
   .out_ready (out_ready)
);

// File: tb/atm_cell_out_fmt_tb_top.sv
module atm_cell_out_fmt_tb_top;
   localparam int CELLB = 52;
   localparam int MAXC  = 32;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wide_mode = 1'b0;
   logic        alt_layout = 1'b0;
   logic [7:0]  udb1_val = 8'h00;
   logic        src_valid = 1'b0;
   logic [7:0]  src_byte = 8'h00;
   logic        src_take;
   logic [15:0] out_data;
   logic        out_soc;
   logic        out_valid;
   logic        out_ready = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   atm_cell_out_fmt dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wide_mode  (wide_mode),
      .alt_layout (alt_layout),
      .udb1_val   (udb1_val),
      .src_valid  (src_valid),
      .src_byte   (src_byte),
      .src_take   (src_take),
      .out_data   (out_data),
      .out_soc    (out_soc),
      .out_valid  (out_valid),
      .out_ready  (out_ready)
   );

   int checks = 0;
   int fails  = 0;
   int take_idx = 0;
   int quota = 0;
   int mcell = 0;
   int mw = 0;
   bit src_en = 0;
   bit rnd_src = 0;
   bit rnd_rdy = 0;
   logic [15:0] lfsr = 16'hACE1;
   bit          prev_stall = 0;
   logic [15:0] prev_data;
   logic        prev_soc;

   bit        exp_wide [MAXC];
   bit        exp_alt  [MAXC];
   logic [7:0] exp_udb [MAXC];
   string     exp_tag  [MAXC];

   function automatic logic [7:0] gen_byte(int c, int j);
      return 8'((c * 37 + j * 5 + 3) % 256);
   endfunction

   function automatic logic [7:0] slot_byte(int c, int s);
      if (s < 4) return gen_byte(c, s);
      if (s == 4) return exp_udb[c];
      if (exp_wide[c] && !exp_alt[c]) return (s == 5) ? 8'h00 : gen_byte(c, s - 2);
      if (s >= 53) return 8'h00;
      return gen_byte(c, s - 1);
   endfunction

   function automatic logic [15:0] exp_word(int c, int w);
      if (exp_wide[c]) return {slot_byte(c, 2 * w), slot_byte(c, 2 * w + 1)};
      return {8'h00, slot_byte(c, w)};
   endfunction

   function automatic int n_words(int c);
      return exp_wide[c] ? 27 : 53;
   endfunction

   task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h (cell %0d word %0d)", req, act, exp, mcell, mw);
      end
   endtask

   // Input driver: just after each rising edge
   always @(posedge clk) begin
      #1;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      src_valid = src_en && (take_idx < quota) && (!rnd_src || lfsr[3] || lfsr[7]);
      src_byte  = gen_byte(take_idx / CELLB, take_idx % CELLB);
      out_ready = !rnd_rdy || lfsr[5] || lfsr[11];
   end

   // Monitor: at the falling edge
   always @(negedge clk) begin
      if (rst_n) begin
         if (prev_stall) begin
            chk(out_valid && out_data == prev_data && out_soc == prev_soc, "R8 hold",
                {15'd0, out_soc, out_data}, {15'd0, prev_soc, prev_data});
         end
         if (out_valid && !out_ready) begin
            chk(!src_take, "R8 no take in stall", 32'(src_take), 32'd0);
         end
         prev_stall = out_valid && !out_ready;
         prev_data  = out_data;
         prev_soc   = out_soc;
         if (src_take) begin
            chk(src_valid, "R9 take needs valid", 32'(src_valid), 32'd1);
            take_idx++;
         end
         if (out_valid && out_ready) begin
            chk(out_data == exp_word(mcell, mw), exp_tag[mcell], 32'(out_data), 32'(exp_word(mcell, mw)));
            chk(out_soc == (mw == 0), "R6 soc", 32'(out_soc), 32'(mw == 0));
            mw++;
            if (mw == n_words(mcell)) begin
               mw = 0;
               mcell++;
            end
         end
      end
   end

   task automatic wait_cells(int target);
      while (mcell < target) @(negedge clk);
      repeat (4) @(negedge clk);
      chk(take_idx == quota, "R9 byte count", 32'(take_idx), 32'(quota));
      chk(!out_valid, "R9 idle after cells", 32'(out_valid), 32'd0);
   endtask

   task automatic run_phase(bit w, bit a, logic [7:0] u, int n, bit rs, bit rr, string tag);
      int base = quota / CELLB;
      for (int c = base; c < base + n; c++) begin
         exp_wide[c] = w; exp_alt[c] = a; exp_udb[c] = u; exp_tag[c] = tag;
      end
      @(posedge clk); #2;
      wide_mode = w; alt_layout = a; udb1_val = u;
      rnd_src = rs; rnd_rdy = rr; src_en = 1;
      quota += n * CELLB;
      wait_cells(base + n);
   endtask

   task automatic run_flip(bit w0, bit a0, bit w1, bit a1, logic [7:0] u);
      int base = quota / CELLB;
      exp_wide[base] = w0;   exp_alt[base] = a0;   exp_udb[base] = u;   exp_tag[base] = "R7 old";
      exp_wide[base+1] = w1; exp_alt[base+1] = a1; exp_udb[base+1] = u; exp_tag[base+1] = "R7 new";
      @(posedge clk); #2;
      wide_mode = w0; alt_layout = a0; udb1_val = u;
      rnd_src = 1; rnd_rdy = 1; src_en = 1;
      quota += 2 * CELLB;
      while (!(mcell == base && mw >= 5)) @(negedge clk);
      @(posedge clk); #2;
      wide_mode = w1; alt_layout = a1;
      wait_cells(base + 2);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!out_valid && !out_soc, "R1 in reset", {30'd0, out_valid, out_soc}, 32'd0);
      @(posedge clk); #2;
      rst_n = 1'b1;
      repeat (5) begin
         @(negedge clk);
         chk(!out_valid && !out_soc && !src_take, "R1 idle after reset",
             {29'd0, out_valid, out_soc, src_take}, 32'd0);
      end
      run_phase(0, 0, 8'h5A, 2, 0, 0, "R2 narrow");
      run_phase(0, 1, 8'hC3, 2, 1, 1, "R2 narrow gaps");
      run_phase(1, 0, 8'h7E, 2, 0, 0, "R3 R5 wide layout one");
      run_phase(1, 0, 8'h81, 3, 1, 1, "R3 R5 wide layout one gaps");
      run_phase(1, 1, 8'h3C, 2, 0, 0, "R4 R5 wide layout two");
      run_phase(1, 1, 8'hE7, 3, 1, 1, "R4 R5 wide layout two gaps");
      run_flip(1, 1, 0, 0, 8'h96);
      run_flip(0, 0, 1, 0, 8'h69);
      run_flip(1, 0, 1, 1, 8'hF0);
      run_phase(0, 0, 8'h0F, 1, 1, 1, "R2 narrow after flips");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion (cell %0d)", mcell);
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule